// File: doc/BRIEF.md
# Looping Ring-Buffer DMA Position Counter

This block keeps the position state of one audio DMA channel that plays out of, or records into, a circular buffer in memory. Software programs a buffer base address, a frame register (buffer length and current word index) and a sample register (interrupt period and remaining count). An external bus master asks for a burst by presenting the most bytes it is able to move. The block then answers with the byte address to use and the number of bytes it may move, and commits the move to its counters at the same moment.

Buffer position is counted in 32-bit words, while the interrupt period is counted in samples whose size depends on the channel format. A two-bit byte carry connects the two granularities, so bursts of any whole-sample length keep the word index exact. When the sample period runs out, the remaining count reloads and a completion pulse is produced. If interrupts are enabled for the channel, that pulse also latches a pending flag. A parameter removes the pause control, which suits a capture channel.

Top module: `ring_dma_counter`

## Requirements
- R1: After reset the frame register, sample register, byte carry, burst outputs, completion pulse and pending flag are all zero.
- R2: With cfg_wr high, cfg_sel picks a register: 0 loads the full base address, 1 loads the frame register (size in bits 15:0, index in bits 31:16) and clears the byte carry, 2 loads only bits 15:0 (the period) of the sample register, so its bits 31:16 are kept.
- R3: The format code fmt has bit 0 = stereo and bit 1 = 16-bit. The bytes per sample are 2 to the power fmt[0]+fmt[1], and the requested byte count is rounded down to a whole number of samples.
- R4: The granted length is the smallest of three values: the rounded request, the bytes left in the buffer ((size - index + 1)*4 + carry), and the bytes left in the period ((remaining + 1) * bytes per sample).
- R5: One cycle after an accepted request, burst_valid is high, burst_len holds the granted length, and burst_addr equals base + 4*index + carry, using the state before the burst.
- R6: A burst that uses up the period exactly reloads the remaining count from the period field and pulses evt_done in the same cycle as burst_valid. Any other burst sets the remaining count to (period bytes left - granted - 1) >> shift.
- R7: With loop_sel = 0, after a burst the index grows by (granted + carry) / 4 and wraps to 0 if the result exceeds size. The carry always becomes (granted + carry) mod 4.
- R8: With loop_sel = 1, a burst leaves the frame register unchanged but still updates the sample register and the byte carry.
- R9: A request is served only when chan_en is high and chan_pause is low. In the capture variant (HAS_PAUSE = 0), chan_pause has no effect.
- R10: A request whose granted length is zero, or one that arrives in the same cycle as cfg_wr, produces no burst_valid and changes no counter.
- R11: irq_pend is set by a completion only while int_en is high, and it reads 0 in the cycle after any cycle in which int_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 frame, 2 sample |
| cfg_wdata | input | ADDR_W | Write data |
| fmt | input | 2 | Sample format: bit 0 stereo, bit 1 16-bit |
| chan_en | input | 1 | Channel enable |
| chan_pause | input | 1 | Pause (ignored when HAS_PAUSE = 0) |
| int_en | input | 1 | Completion interrupt enable |
| loop_sel | input | 1 | 0 = loop (index advances), 1 = index frozen |
| burst_req | input | 1 | Burst request |
| burst_bytes | input | CNT_W | Maximum bytes the master can move |
| burst_valid | output | 1 | Grant is valid this cycle |
| burst_addr | output | ADDR_W | Byte address of the granted burst |
| burst_len | output | CNT_W | Granted byte count |
| evt_done | output | 1 | Sample period exhausted by this burst |
| irq_pend | output | 1 | Latched completion interrupt |
| frame_cnt | output | 2*CNT_W | {index, size} |
| samp_cnt | output | 2*CNT_W | {remaining, period} |
| byte_carry | output | 2 | Sub-word leftover bytes |

## Verification
All results are registered. A request or register write that is presented before a rising edge appears on the outputs right after that edge: burst_valid, burst_addr, burst_len, evt_done, irq_pend and the updated counter registers all change at the same edge. The bench drives every stimulus on a falling edge and samples at the next falling edge, exactly one edge later. When int_en falls, the pending flag is checked one edge later. Cases that must have no effect are checked by reading the frame register, sample register and byte carry one edge after the stimulus.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    typedef enum logic [1:0] {
        RDC_SEL_BASE   = 2'd0,
        RDC_SEL_FRAME  = 2'd1,
        RDC_SEL_SAMPLE = 2'd2,
        RDC_SEL_NONE   = 2'd3
    } rdc_sel_e;

    // log2 of bytes per sample: stereo adds one, 16-bit adds one
    function automatic logic [1:0] rdc_shift(input logic [1:0] fmt);
        return {1'b0, fmt[0]} + {1'b0, fmt[1]};
    endfunction

endpackage

// File: rtl/rdc_burst_calc.sv
module rdc_burst_calc
    import rdc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [1:0]        fmt,
    input  logic [CNT_W-1:0]  req_bytes,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  idx,
    input  logic [CNT_W-1:0]  size,
    input  logic [CNT_W-1:0]  remain,
    input  logic [1:0]        carry,
    output logic [1:0]        shift,
    output logic [CNT_W+2:0]  period_bytes,
    output logic [CNT_W-1:0]  len,
    output logic [ADDR_W-1:0] addr
);
    localparam int BW = CNT_W + 3;

    logic [CNT_W-1:0] rounded;
    logic [BW-1:0]    words_left;
    logic [BW-1:0]    buf_bytes;
    logic [BW-1:0]    lim_a;

    always_comb begin
        shift        = rdc_shift(fmt);
        rounded      = req_bytes & ~((CNT_W'(1) << shift) - CNT_W'(1));
        words_left   = {3'b000, size} - {3'b000, idx} + BW'(1);
        buf_bytes    = (words_left << 2) + BW'(carry);
        period_bytes = ({3'b000, remain} + BW'(1)) << shift;
        lim_a        = (buf_bytes < period_bytes) ? buf_bytes : period_bytes;
        len          = ({3'b000, rounded} < lim_a) ? rounded : CNT_W'(lim_a);
        addr         = base + ADDR_W'({idx, 2'b00}) + ADDR_W'(carry);
    end

endmodule

// File: rtl/rdc_advance.sv
module rdc_advance #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] len,
    input  logic [1:0]       carry,
    input  logic [1:0]       shift,
    input  logic [CNT_W-1:0] idx,
    input  logic [CNT_W-1:0] size,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W+2:0] period_bytes,
    output logic [CNT_W-1:0] idx_next,
    output logic [1:0]       carry_next,
    output logic [CNT_W-1:0] remain_next,
    output logic             period_hit
);
    localparam int BW = CNT_W + 3;

    logic [CNT_W:0] sum;
    logic [CNT_W:0] adv;
    logic [BW-1:0]  left_after;

    always_comb begin
        sum        = {1'b0, len} + {{(CNT_W-1){1'b0}}, carry};
        carry_next = sum[1:0];
        adv        = {1'b0, idx} + {2'b00, sum[CNT_W:2]};
        idx_next   = (adv > {1'b0, size}) ? '0 : adv[CNT_W-1:0];
        period_hit = ({3'b000, len} == period_bytes);
        left_after = period_bytes - {3'b000, len} - BW'(1);
        remain_next = period_hit ? period : CNT_W'(left_after >> shift);
    end

endmodule

// File: rtl/ring_dma_counter.sv
module ring_dma_counter
    import rdc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter bit HAS_PAUSE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [1:0]           cfg_sel,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    input  logic [1:0]           fmt,
    input  logic                 chan_en,
    input  logic                 chan_pause,
    input  logic                 int_en,
    input  logic                 loop_sel,
    input  logic                 burst_req,
    input  logic [CNT_W-1:0]     burst_bytes,
    output logic                 burst_valid,
    output logic [ADDR_W-1:0]    burst_addr,
    output logic [CNT_W-1:0]     burst_len,
    output logic                 evt_done,
    output logic                 irq_pend,
    output logic [2*CNT_W-1:0]   frame_cnt,
    output logic [2*CNT_W-1:0]   samp_cnt,
    output logic [1:0]           byte_carry
);
    localparam int BW = CNT_W + 3;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  idx;
        logic [CNT_W-1:0]  size;
        logic [CNT_W-1:0]  remain;
        logic [CNT_W-1:0]  period;
        logic [1:0]        carry;
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  len;
        logic              done;
        logic              pend;
    } state_t;

    state_t st_d, st_q;

    logic              run;
    logic              go;
    logic [1:0]        shift;
    logic [BW-1:0]     period_bytes;
    logic [CNT_W-1:0]  grant_len;
    logic [ADDR_W-1:0] grant_addr;
    logic [CNT_W-1:0]  idx_next;
    logic [1:0]        carry_next;
    logic [CNT_W-1:0]  remain_next;
    logic              period_hit;

    generate
        if (HAS_PAUSE) begin : g_pause
            assign run = chan_en & ~chan_pause;
        end else begin : g_nopause
            assign run = chan_en;
        end
    endgenerate

    rdc_burst_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_calc (
        .fmt          (fmt),
        .req_bytes    (burst_bytes),
        .base         (st_q.base),
        .idx          (st_q.idx),
        .size         (st_q.size),
        .remain       (st_q.remain),
        .carry        (st_q.carry),
        .shift        (shift),
        .period_bytes (period_bytes),
        .len          (grant_len),
        .addr         (grant_addr)
    );

    rdc_advance #(.CNT_W(CNT_W)) i_adv (
        .len          (grant_len),
        .carry        (st_q.carry),
        .shift        (shift),
        .idx          (st_q.idx),
        .size         (st_q.size),
        .period       (st_q.period),
        .period_bytes (period_bytes),
        .idx_next     (idx_next),
        .carry_next   (carry_next),
        .remain_next  (remain_next),
        .period_hit   (period_hit)
    );

    assign go = burst_req & run & ~cfg_wr & (grant_len != '0);

    always_comb begin
        st_d       = st_q;
        st_d.valid = go;
        st_d.done  = go & period_hit;
        if (go) begin
            st_d.addr   = grant_addr;
            st_d.len    = grant_len;
            st_d.remain = remain_next;
            st_d.carry  = carry_next;
            if (!loop_sel) begin
                st_d.idx = idx_next;
            end
        end
        st_d.pend = int_en & (st_q.pend | (go & period_hit));
        if (cfg_wr) begin
            case (rdc_sel_e'(cfg_sel))
                RDC_SEL_BASE: st_d.base = cfg_wdata;
                RDC_SEL_FRAME: begin
                    st_d.size  = cfg_wdata[CNT_W-1:0];
                    st_d.idx   = cfg_wdata[2*CNT_W-1:CNT_W];
                    st_d.carry = 2'b00;
                end
                RDC_SEL_SAMPLE: st_d.period = cfg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign burst_valid = st_q.valid;
    assign burst_addr  = st_q.addr;
    assign burst_len   = st_q.len;
    assign evt_done    = st_q.done;
    assign irq_pend    = st_q.pend;
    assign frame_cnt   = {st_q.idx, st_q.size};
    assign samp_cnt    = {st_q.remain, st_q.period};
    assign byte_carry  = st_q.carry;

endmodule

// File: rtl/rdc_checker.sv
module rdc_checker
    import rdc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr,
    input logic [1:0]         cfg_sel,
    input logic [1:0]         fmt,
    input logic               chan_en,
    input logic               int_en,
    input logic               loop_sel,
    input logic               burst_req,
    input logic [CNT_W-1:0]   burst_bytes,
    input logic               burst_valid,
    input logic [CNT_W-1:0]   burst_len,
    input logic               evt_done,
    input logic               irq_pend,
    input logic [2*CNT_W-1:0] frame_cnt,
    input logic [1:0]         byte_carry
);
    logic [1:0]       fmt_q;
    logic [CNT_W-1:0] req_q;
    logic             loop_q;
    logic [CNT_W-1:0] sample_mask;
    logic [CNT_W-1:0] req_mask_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q  <= 2'b00;
            req_q  <= '0;
            loop_q <= 1'b0;
        end else begin
            fmt_q  <= fmt;
            req_q  <= burst_bytes;
            loop_q <= loop_sel;
        end
    end

    assign sample_mask  = (CNT_W'(1) << rdc_shift(fmt_q)) - CNT_W'(1);
    assign req_mask_now = (CNT_W'(1) << rdc_shift(fmt)) - CNT_W'(1);

    // R3
    whole_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> ((burst_len & sample_mask) == '0));

    // R4
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> (burst_len <= req_q && burst_len != '0));

    // R7
    index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid && !loop_q) |-> (frame_cnt[2*CNT_W-1:CNT_W] <= frame_cnt[CNT_W-1:0]));

    // R6
    done_with_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |-> burst_valid);

    // R9
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !burst_valid);

    // R11
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |=> !irq_pend);

    // R2
    carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == 2'd1) |=> (byte_carry == 2'b00));

    // R10
    zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_req && ((burst_bytes & ~req_mask_now) == '0)) |=> !burst_valid);

endmodule

bind ring_dma_counter rdc_checker #(.CNT_W(CNT_W)) i_rdc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_sel     (cfg_sel),
    .fmt         (fmt),
    .chan_en     (chan_en),
    .int_en      (int_en),
    .loop_sel    (loop_sel),
    .burst_req   (burst_req),
    .burst_bytes (burst_bytes),
    .burst_valid (burst_valid),
    .burst_len   (burst_len),
    .evt_done    (evt_done),
    .irq_pend    (irq_pend),
    .frame_cnt   (frame_cnt),
    .byte_carry  (byte_carry)
);

// File: tb/test_ring_dma_counter.sv
module test_ring_dma_counter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd3;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  fmt = 2'd3;
    logic        chan_en = 1'b1;
    logic        chan_pause = 1'b0;
    logic        int_en = 1'b1;
    logic        loop_sel = 1'b0;
    logic        burst_req = 1'b0;
    logic [15:0] burst_bytes = '0;

    logic        burst_valid, evt_done, irq_pend;
    logic [31:0] burst_addr, frame_cnt, samp_cnt;
    logic [15:0] burst_len;
    logic [1:0]  byte_carry;

    logic        c_valid, c_done, c_pend;
    logic [31:0] c_addr, c_frame, c_samp;
    logic [15:0] c_len;
    logic [1:0]  c_carry;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_dma_counter i_ring_dma_counter (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .fmt(fmt), .chan_en(chan_en),
        .chan_pause(chan_pause), .int_en(int_en), .loop_sel(loop_sel),
        .burst_req(burst_req), .burst_bytes(burst_bytes),
        .burst_valid(burst_valid), .burst_addr(burst_addr),
        .burst_len(burst_len), .evt_done(evt_done), .irq_pend(irq_pend),
        .frame_cnt(frame_cnt), .samp_cnt(samp_cnt), .byte_carry(byte_carry)
    );

    ring_dma_counter #(.HAS_PAUSE(1'b0)) i_ring_dma_counter_cap (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .fmt(fmt), .chan_en(chan_en),
        .chan_pause(chan_pause), .int_en(int_en), .loop_sel(loop_sel),
        .burst_req(burst_req), .burst_bytes(burst_bytes),
        .burst_valid(c_valid), .burst_addr(c_addr),
        .burst_len(c_len), .evt_done(c_done), .irq_pend(c_pend),
        .frame_cnt(c_frame), .samp_cnt(c_samp), .byte_carry(c_carry)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_sel = 2'd3;
    endtask

    task automatic burst(input logic [1:0] f, input logic [15:0] bytes);
        @(negedge clk);
        fmt = f; burst_req = 1'b1; burst_bytes = bytes;
        @(negedge clk);
        burst_req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 frame", frame_cnt, 32'h0);
        chk("R1 sample", samp_cnt, 32'h0);
        chk("R1 carry", {30'b0, byte_carry}, 32'h0);
        chk("R1 valid/done/pend", {29'b0, burst_valid, evt_done, irq_pend}, 32'h0);
    endtask

    task automatic t_config;
        cfg_write(2'd0, 32'h0000_1000);
        cfg_write(2'd1, 32'h0000_0007);
        chk("R2 frame write", frame_cnt, 32'h0000_0007);
        cfg_write(2'd2, 32'hFFFF_0003);
        chk("R2 sample keeps upper half", samp_cnt, 32'h0000_0003);
    endtask

    task automatic t_period_limited;
        burst(2'd3, 16'd10);
        chk("R5 valid", {31'b0, burst_valid}, 32'h1);
        chk("R5 addr", burst_addr, 32'h0000_1000);
        chk("R4 period-limited len", {16'b0, burst_len}, 32'd4);
        chk("R6 done", {31'b0, evt_done}, 32'h1);
        chk("R6 reload", samp_cnt, 32'h0003_0003);
        chk("R7 index +1", frame_cnt, 32'h0001_0007);
        chk("R11 pend set", {31'b0, irq_pend}, 32'h1);
        @(negedge clk);
        chk("R6 done is a pulse", {31'b0, evt_done}, 32'h0);
        int_en = 1'b0;
        @(negedge clk);
        chk("R11 pend cleared", {31'b0, irq_pend}, 32'h0);
        int_en = 1'b1;
    endtask

    task automatic t_partial_period;
        burst(2'd3, 16'd6);
        chk("R3 rounded len", {16'b0, burst_len}, 32'd4);
        chk("R5 addr 2", burst_addr, 32'h0000_1004);
        chk("R6 no done", {31'b0, evt_done}, 32'h0);
        chk("R6 remaining", samp_cnt, 32'h0002_0003);
        chk("R11 pend stays", {31'b0, irq_pend}, 32'h0);
    endtask

    task automatic t_carry;
        burst(2'd0, 16'd3);
        chk("R5 addr 3", burst_addr, 32'h0000_1008);
        chk("R6 done 8-bit", {31'b0, evt_done}, 32'h1);
        chk("R7 index held", frame_cnt, 32'h0002_0007);
        chk("R7 carry 3", {30'b0, byte_carry}, 32'd3);
        burst(2'd0, 16'd2);
        chk("R5 addr with carry", burst_addr, 32'h0000_100B);
        chk("R7 index via carry", frame_cnt, 32'h0003_0007);
        chk("R7 carry 1", {30'b0, byte_carry}, 32'd1);
        chk("R6 remaining 8-bit", samp_cnt, 32'h0001_0003);
        cfg_write(2'd1, 32'h0003_0007);
        chk("R2 carry cleared", {30'b0, byte_carry}, 32'd0);
    endtask

    task automatic t_wrap;
        cfg_write(2'd2, 32'h0000_00FF);
        chk("R2 period write", samp_cnt, 32'h0001_00FF);
        cfg_write(2'd1, 32'h0007_0007);
        burst(2'd2, 16'd100);
        chk("R5 addr last word", burst_addr, 32'h0000_101C);
        chk("R4 len both limits", {16'b0, burst_len}, 32'd4);
        chk("R7 wrap to 0", frame_cnt, 32'h0000_0007);
        chk("R6 reload 16-bit", samp_cnt, 32'h00FF_00FF);
        cfg_write(2'd1, 32'h0007_0007);
        burst(2'd2, 16'd100);
        chk("R4 buffer-limited len", {16'b0, burst_len}, 32'd4);
        chk("R6 no done buffer", {31'b0, evt_done}, 32'h0);
        chk("R6 remaining 16-bit", samp_cnt, 32'h00FD_00FF);
        chk("R7 wrap again", frame_cnt, 32'h0000_0007);
    endtask

    task automatic t_no_loop;
        loop_sel = 1'b1;
        burst(2'd2, 16'd6);
        loop_sel = 1'b0;
        chk("R8 len", {16'b0, burst_len}, 32'd6);
        chk("R8 frame frozen", frame_cnt, 32'h0000_0007);
        chk("R8 carry updates", {30'b0, byte_carry}, 32'd2);
        chk("R8 sample updates", samp_cnt, 32'h00FA_00FF);
        burst(2'd1, 16'd5);
        chk("R3 stereo rounding", {16'b0, burst_len}, 32'd4);
        chk("R5 addr carry 2", burst_addr, 32'h0000_1002);
        chk("R7 index 1", frame_cnt, 32'h0001_0007);
        chk("R6 remaining stereo", samp_cnt, 32'h00F8_00FF);
    endtask

    task automatic t_ignored;
        burst(2'd3, 16'd3);
        chk("R10 zero grant no valid", {31'b0, burst_valid}, 32'h0);
        chk("R10 frame unchanged", frame_cnt, 32'h0001_0007);
        chk("R10 sample unchanged", samp_cnt, 32'h00F8_00FF);
        chk("R10 carry unchanged", {30'b0, byte_carry}, 32'd2);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h0000_2000;
        fmt = 2'd3; burst_req = 1'b1; burst_bytes = 16'd8;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_sel = 2'd3; burst_req = 1'b0;
        chk("R10 write blocks burst", {31'b0, burst_valid}, 32'h0);
        chk("R10 frame after blocked", frame_cnt, 32'h0001_0007);
        chan_en = 1'b0;
        burst(2'd3, 16'd8);
        chk("R9 disabled no valid", {31'b0, burst_valid}, 32'h0);
        chk("R9 disabled frame", frame_cnt, 32'h0001_0007);
        chan_en = 1'b1;
        chan_pause = 1'b1;
        burst(2'd3, 16'd8);
        chan_pause = 1'b0;
        chk("R9 paused no valid", {31'b0, burst_valid}, 32'h0);
        chk("R9 paused sample", samp_cnt, 32'h00F8_00FF);
        chk("R9 capture ignores pause", {31'b0, c_valid}, 32'h1);
        chk("R9 capture addr", c_addr, 32'h0000_2006);
        chk("R9 capture len", {16'b0, c_len}, 32'd8);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_period_limited();
        t_partial_period();
        t_carry();
        t_wrap();
        t_no_loop();
        t_ignored();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule